// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a SPI master that software controls through a small register file. Software configures a control word, writes words into a transmit queue and reads received words from a receive queue. The core drives the serial clock, the data output and a group of active-low chip selects, and it samples the data input. It shifts a word every time the transmit queue has data. A status word and a per-bit interrupt enable provide interrupt signalling.

The serial clock comes from the system clock through a 4-bit divider and two optional stages: one divides by 2 and one divides by 16. The word length can be any value from 4 to 16 bits, or it can be 32 bits. The bit order, clock polarity and clock phase are programmable. Inside the 32-bit data registers, the position of a word depends on its length and its bit order, so software can reach the value with a fixed shift. A loopback setting feeds the data output back into the receiver.

Top module: `spi_master`

## Requirements
- R1: After reset: the control word reads 0, the status word reads 0x100 (only the transmit-not-full bit is set), the chip-select register and the `ss_n` pins are all ones, and `sck` is 0. The capability word reads {NSS[7:0], 7'b0, 1'b1, DEPTH[7:0], 8'h00}.
- R2: One full `sck` period lasts 2 × (F ? 1 : 2) × (P+1) × (D ? 16 : 1) system clocks. P is control[19:16], D is control[27] and F is control[13].
- R3: With MSB-first order (control[26]=1), bits are sent starting from bit 31 and moving down. A received word of length L<32 occupies bits [16+L-1:16] and all other bits read 0. A 32-bit word (control[23:20]=0) uses the whole register with no shift. Bits outside the word in the transmit value have no effect.
- R4: With LSB-first order (control[26]=0), bits are sent starting from bit 0 and moving up. A received word of length L<32 occupies bits [15:16-L]. For lengths below 32, the length field control[23:20] holds L-1.
- R5: While no word is shifting, `sck` rests at the polarity bit control[29]. With clock phase control[28]=0, `mosi` is stable on each leading edge of `sck`, and the first bit sent follows the bit order.
- R6: When the loopback bit control[30] is 1, the receiver takes `mosi` and ignores `miso`. When it is 0, the receiver samples `miso`.
- R7: While the enable bit control[24] is 1, a write to the control word changes only the enable bit.
- R8: A write to the transmit register (address 4) is dropped while the enable bit is 0, and clearing the enable bit empties the transmit queue.
- R9: A word that completes while the receive queue holds DEPTH words is discarded and sets the overrun bit (status bit 12). The words already queued are kept, and writing 1 to bit 12 clears the overrun bit.
- R10: Status bit 9 is 1 when the receive queue is not empty. Status bit 8 is 1 when the transmit queue is not full. Status bit 14 is set when a word completes while the transmit queue is empty, and writing 1 to bit 14 clears it.
- R11: `irq` is 1 exactly when some status bit and the matching bit of the interrupt enable register (address 3) are both 1.
- R12: The `ss_n` pins follow the chip-select register (address 6) directly, and the register reads back its written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 3 | Word address: 0 capability, 1 control, 2 status, 3 interrupt enable, 4 transmit, 5 receive, 6 chip select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address (combinational); a read of address 5 pops the receive queue |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low chip selects |

## Verification
The bench builds the block with its default parameters: DEPTH=4 and NSS=4. A four-entry receive queue overflows after only five back-to-back loopback words, so the overrun path can be tested in a few hundred cycles. With the divider set to its largest value, a full transmit queue can be held long enough to observe the transmit-not-full bit at 0. The divider tests cover the fastest setting, each extra divide stage, and the slowest setting of 1024 system clocks per `sck` period.

// File: rtl/spi_master.sv
`timescale 1ns/1ps
module spi_master #(
  parameter int DEPTH = 4,
  parameter int NSS   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_en,
  input  logic           reg_we,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NSS-1:0] ss_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [2:0] A_CAP = 3'd0, A_CTL = 3'd1, A_STS = 3'd2, A_IEN = 3'd3,
                         A_TX  = 3'd4, A_RX  = 3'd5, A_SEL = 3'd6;
  localparam logic [31:0] CTL_MASK = 32'h7FFF_2000;
  localparam logic [31:0] IEN_MASK = 32'h0000_5F00;
  localparam logic [31:0] CAP_WORD = {8'(NSS), 7'd0, 1'b1, 8'(DEPTH), 8'h00};

  logic [31:0] ctl_q, ien_q;
  logic [NSS-1:0] sel_q;
  logic lt_q, ov_q;

  wire loop_b = ctl_q[30];
  wire cpol   = ctl_q[29];
  wire cpha   = ctl_q[28];
  wire div16  = ctl_q[27];
  wire msbf   = ctl_q[26];
  wire en     = ctl_q[24];
  wire [3:0] len = ctl_q[23:20];
  wire [3:0] pm  = ctl_q[19:16];
  wire fact   = ctl_q[13];

  wire wr = reg_en &  reg_we;
  wire rd = reg_en & ~reg_we;

  // Clock divider
  wire [4:0] base  = {1'b0, pm} + 5'd1;
  wire [9:0] t1    = fact ? {5'd0, base} : {4'd0, base, 1'b0};
  wire [9:0] half  = div16 ? {t1[5:0], 4'd0} : t1;
  wire [9:0] h_lim = half - 10'd1;

  wire [5:0] nbits    = (len == 4'd0) ? 6'd32 : {2'b00, len} + 6'd1;
  wire [5:0] last_edg = {nbits[4:0], 1'b0} - 6'd1;

  // Queues
  logic [31:0] tx_mem [DEPTH];
  logic [31:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  // Shifter
  logic        busy, phase;
  logic [9:0]  div_q;
  logic [5:0]  ecnt;
  logic [31:0] txsh, rxsh;

  assign mosi = msbf ? txsh[31] : txsh[0];
  assign sck  = cpol ^ phase;
  wire din    = loop_b ? mosi : miso;

  wire tick     = busy && (div_q == h_lim);
  wire leading  = ~ecnt[0];
  wire samp     = cpha ? ~leading : leading;
  wire shft     = ~samp && !(cpha && ecnt == 6'd0);
  wire [31:0] rx_in = msbf ? {rxsh[30:0], din} : {din, rxsh[31:1]};
  wire [31:0] rx_nx = (tick && samp) ? rx_in : rxsh;
  wire done     = tick && (ecnt == last_edg);
  wire [31:0] rx_word = (len == 4'd0) ? rx_nx : (msbf ? (rx_nx << 16) : (rx_nx >> 16));

  wire tx_push = wr && reg_addr == A_TX && en && tx_cnt != FULL;
  wire start   = en && !busy && tx_cnt != '0;
  wire rx_push = done && rx_cnt != FULL;
  wire rx_pop  = rd && reg_addr == A_RX && rx_cnt != '0;

  wire ne = rx_cnt != '0;
  wire nf = tx_cnt != FULL;
  wire [31:0] status = {17'd0, lt_q, 1'b0, ov_q, 2'b00, ne, nf, 8'd0};

  assign irq  = |(status & ien_q);
  assign ss_n = sel_q;

  always_comb begin
    case (reg_addr)
      A_CAP:   reg_rdata = CAP_WORD;
      A_CTL:   reg_rdata = ctl_q;
      A_STS:   reg_rdata = status;
      A_IEN:   reg_rdata = ien_q;
      A_RX:    reg_rdata = ne ? rx_mem[rx_rp] : 32'd0;
      A_SEL:   reg_rdata = 32'(sel_q);
      default: reg_rdata = 32'd0;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      ien_q <= '0;
      sel_q <= '1;
      lt_q  <= 1'b0;
      ov_q  <= 1'b0;
    end else begin
      if (wr && reg_addr == A_CTL) begin
        if (!en) ctl_q <= reg_wdata & CTL_MASK;
        else     ctl_q[24] <= reg_wdata[24];
      end
      if (wr && reg_addr == A_IEN) ien_q <= reg_wdata & IEN_MASK;
      if (wr && reg_addr == A_SEL) sel_q <= reg_wdata[NSS-1:0];
      if (done && tx_cnt == '0)                    lt_q <= 1'b1;
      else if (wr && reg_addr == A_STS && reg_wdata[14]) lt_q <= 1'b0;
      if (done && rx_cnt == FULL)                  ov_q <= 1'b1;
      else if (wr && reg_addr == A_STS && reg_wdata[12]) ov_q <= 1'b0;
    end
  end

  // Transmit queue
  always_ff @(posedge clk) if (tx_push) tx_mem[tx_wp] <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
    end else if (!en) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
    end
  end

  // Receive queue
  always_ff @(posedge clk) if (rx_push) rx_mem[rx_wp] <= rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  // Shift engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; phase <= 1'b0; div_q <= '0; ecnt <= '0;
      txsh <= '0;   rxsh  <= '0;
    end else if (!en) begin
      busy <= 1'b0; phase <= 1'b0; div_q <= '0; ecnt <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      phase <= 1'b0;
      div_q <= '0;
      ecnt  <= '0;
      txsh  <= tx_mem[tx_rp];
      rxsh  <= '0;
    end else if (busy) begin
      if (tick) begin
        div_q <= '0;
        phase <= ~phase;
        ecnt  <= ecnt + 6'd1;
        rxsh  <= rx_nx;
        if (shft) txsh <= msbf ? (txsh << 1) : (txsh >> 1);
        if (done) busy <= 1'b0;
      end else begin
        div_q <= div_q + 10'd1;
      end
    end
  end

  // Assertions
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));
  a_r7_ctl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(ctl_q[31:25]) && $stable(ctl_q[23:0])));
  a_r8_tx_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_cnt == '0 && !busy));
  a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_cnt == FULL) |=> (ov_q && $stable(rx_cnt)));
  a_r10_queue_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= FULL) && (rx_cnt <= FULL));
  a_r10_last_char: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tx_cnt == '0) |=> lt_q);
endmodule

// File: tb/spi_master_tb.sv
`timescale 1ns/1ps
module spi_master_tb;
  logic clk = 0, rst_n = 0;
  logic reg_en = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, sck, mosi, miso = 0;
  logic [3:0] ss_n;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  spi_master #(.DEPTH(4), .NSS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  // {cpol, cpha, msb-first, len, tx, expected rx}
  localparam int NV = 11;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,4'd7, 32'hA5FF_FFFF, 32'h00A5_0000},
    {1'b0,1'b0,1'b0,4'd7, 32'hFFFF_FFA5, 32'h0000_A500},
    {1'b0,1'b0,1'b1,4'd15,32'h1234_0000, 32'h1234_0000},
    {1'b0,1'b0,1'b0,4'd15,32'h0000_BEEF, 32'h0000_BEEF},
    {1'b0,1'b0,1'b1,4'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {1'b0,1'b0,1'b0,4'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {1'b0,1'b0,1'b1,4'd3, 32'hC000_0000, 32'h000C_0000},
    {1'b0,1'b0,1'b0,4'd3, 32'h0000_000C, 32'h0000_C000},
    {1'b1,1'b1,1'b1,4'd7, 32'h3C00_0000, 32'h003C_0000},
    {1'b0,1'b1,1'b0,4'd11,32'h0000_0ABC, 32'h0000_ABC0},
    {1'b1,1'b0,1'b1,4'd9, 32'hB540_0000, 32'h02D5_0000}
  };

  function automatic logic [31:0] mk(input logic lp, cp, ph, d16, msb,
                                     input logic [3:0] ln, pmv, input logic fa, en);
    return {1'b0, lp, cp, ph, d16, msb, 1'b0, en, ln, pmv, 2'b00, fa, 13'd0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic wait_ne(input int lim);
    logic [31:0] s;
    for (int i = 0; i < lim; i++) begin
      rd(3'd2, s);
      if (s[9]) break;
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic measure(input logic [3:0] pmv, input logic fa, d16, input int exp);
    time t1, t2;
    do_reset();
    wr(3'd1, mk(1, 0, 0, d16, 1, 4'd3, pmv, fa, 1));
    wr(3'd4, 32'h0);
    @(posedge sck); t1 = $time;
    @(posedge sck); t2 = $time;
    chk("R2 sck period", 32'((t2 - t1) / 4), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    logic [7:0] seq;
    do_reset();
    // R1 reset state
    rd(3'd0, v); chk("R1 capability", v, 32'h0401_0400);
    rd(3'd1, v); chk("R1 control", v, 32'h0);
    rd(3'd2, v); chk("R1 status", v, 32'h0000_0100);
    rd(3'd6, v); chk("R1 select reg", v, 32'hF);
    chk("R1 ss_n pins", 32'(ss_n), 32'hF);
    chk("R1 sck", 32'(sck), 32'h0);

    // Table walk: R3 and R4 placement in loopback
    for (int i = 0; i < NV; i++) begin
      logic [70:0] e;
      e = VEC[i];
      wr(3'd1, 32'h0);
      wr(3'd1, mk(1, e[70], e[69], 0, e[68], e[67:64], 4'd0, 1, 1));
      wr(3'd4, e[63:32]);
      wait_ne(200);
      rd(3'd5, v);
      chk(e[68] ? "R3 msb-first placement" : "R4 lsb-first placement", v, e[31:0]);
    end

    // R2 divider
    measure(4'd0, 1, 0, 2);
    measure(4'd3, 0, 0, 16);
    measure(4'd0, 1, 1, 32);
    measure(4'd15, 0, 1, 1024);

    // R5 pin bit order and idle level
    do_reset();
    wr(3'd1, mk(0, 0, 0, 0, 1, 4'd7, 4'd1, 1, 1));
    wr(3'd4, 32'hA500_0000);
    seq = 0;
    for (int b = 0; b < 8; b++) begin @(posedge sck); seq = {seq[6:0], mosi}; end
    chk("R5 msb-first pin order", 32'(seq), 32'hA5);
    wait_ne(200);
    do_reset();
    wr(3'd1, mk(0, 0, 0, 0, 0, 4'd7, 4'd1, 1, 1));
    wr(3'd4, 32'h0000_001E);
    seq = 0;
    for (int b = 0; b < 8; b++) begin @(posedge sck); seq = {seq[6:0], mosi}; end
    chk("R5 lsb-first pin order", 32'(seq), 32'h78);
    wait_ne(200);
    wr(3'd1, 32'h0);
    wr(3'd1, mk(0, 1, 0, 0, 1, 4'd7, 4'd0, 1, 1));
    repeat (3) @(negedge clk);
    chk("R5 idle sck polarity", 32'(sck), 32'h1);

    // R6 miso vs loopback
    do_reset();
    miso = 1;
    wr(3'd1, mk(0, 0, 0, 0, 1, 4'd7, 4'd0, 1, 1));
    wr(3'd4, 32'h0);
    wait_ne(200); rd(3'd5, v);
    chk("R6 miso sampled", v, 32'h00FF_0000);
    wr(3'd1, 32'h0);
    wr(3'd1, mk(1, 0, 0, 0, 1, 4'd7, 4'd0, 1, 1));
    wr(3'd4, 32'h0);
    wait_ne(200); rd(3'd5, v);
    chk("R6 miso ignored in loopback", v, 32'h0);
    miso = 0;

    // R7 control locked while enabled
    do_reset();
    wr(3'd1, mk(1, 0, 0, 0, 1, 4'd7, 4'd2, 1, 1));
    wr(3'd1, mk(0, 1, 1, 1, 0, 4'd15, 4'd9, 0, 1));
    rd(3'd1, v); chk("R7 write ignored while enabled", v, mk(1, 0, 0, 0, 1, 4'd7, 4'd2, 1, 1));
    wr(3'd1, 32'h0);
    rd(3'd1, v); chk("R7 only enable clears", v, mk(1, 0, 0, 0, 1, 4'd7, 4'd2, 1, 0));

    // R8 transmit writes dropped while disabled
    do_reset();
    wr(3'd1, mk(1, 0, 0, 0, 1, 4'd7, 4'd0, 1, 0));
    wr(3'd4, 32'h5A00_0000);
    wr(3'd1, mk(1, 0, 0, 0, 1, 4'd7, 4'd0, 1, 1));
    repeat (100) @(negedge clk);
    rd(3'd2, v); chk("R8 no word sent", v, 32'h0000_0100);

    // R10 / R11 events and interrupt
    do_reset();
    wr(3'd3, 32'h0000_0200);
    chk("R11 irq low before", 32'(irq), 32'h0);
    wr(3'd1, mk(1, 0, 0, 0, 1, 4'd7, 4'd0, 1, 1));
    wr(3'd4, 32'h7700_0000);
    wait_ne(200);
    rd(3'd2, v); chk("R10 ne and last-char", v, 32'h0000_4300);
    chk("R11 irq on enabled event", 32'(irq), 32'h1);
    wr(3'd3, 32'h0);
    chk("R11 irq masked", 32'(irq), 32'h0);
    rd(3'd5, v);
    wr(3'd2, 32'h0000_4000);
    rd(3'd2, v); chk("R10 last-char cleared, ne low", v, 32'h0000_0100);
    do_reset();
    wr(3'd1, mk(1, 0, 0, 1, 1, 4'd7, 4'd15, 0, 1));
    for (int k = 0; k < 5; k++) wr(3'd4, 32'h0);
    rd(3'd2, v); chk("R10 transmit full", v & 32'h100, 32'h0);

    // R9 overrun
    do_reset();
    wr(3'd1, mk(1, 0, 0, 0, 1, 4'd7, 4'd0, 1, 1));
    for (int k = 1; k <= 5; k++) wr(3'd4, 32'(k) << 24);
    repeat (200) @(negedge clk);
    rd(3'd2, v); chk("R9 overrun set", v & 32'h1000, 32'h1000);
    wr(3'd3, 32'h0000_1000);
    chk("R11 irq on overrun", 32'(irq), 32'h1);
    for (int k = 1; k <= 4; k++) begin
      rd(3'd5, v); chk("R9 kept word", v, 32'(k) << 16);
    end
    rd(3'd2, v); chk("R9 fifth word dropped", v & 32'h200, 32'h0);
    wr(3'd2, 32'h0000_1000);
    rd(3'd2, v); chk("R9 overrun cleared", v & 32'h1000, 32'h0);

    // R12 chip selects
    wr(3'd6, 32'h0000_000B);
    chk("R12 ss_n pins", 32'(ss_n), 32'hB);
    rd(3'd6, v); chk("R12 readback", v, 32'hB);

    finish_up();
  end
endmodule